// File: doc/BRIEF.md
# Preemptive Interrupt Priority Controller

This block takes a set of interrupt request lines, each with a 4-bit priority supplied by a configuration array, and raises a single interrupt request to a processor. Only a request whose priority is strictly above the current priority can reach the processor. The winning source is captured in a holding register. That register drives the request output and the vector number until the processor acknowledges it.

When the processor acknowledges, the current priority is pushed onto a last-in/first-out stack and replaced by the priority of the acknowledged source. A later end-of-interrupt write pops the stack and restores the saved level. This lets handlers nest: a higher-priority source can preempt a running handler once the pending capture has been taken. Software can also write the current priority directly, which masks every source at or below the new level while shared data is updated.

There are two ways to acknowledge. In software-vector mode, a read of the acknowledge register is the acknowledge, and that read returns the vector. In hardware-vector mode, the vector is shown on dedicated lines and a handshake input takes the acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0, the current priority is 0, lifo_err_o is 0 and the stack is empty.
- R2: A source reaches the processor only if it is asserted and its priority is strictly greater than the current priority. Equal or lower priority is blocked.
- R3: Among qualifying sources, the highest priority wins. On a tie, the lowest source index wins.
- R4: A captured request keeps irq_o high and its vector unchanged until it is acknowledged, even if a higher-priority request arrives meanwhile.
- R5: In software mode (hw_vec_mode_i=0), a read at address 1 acknowledges the captured request. It returns the source index zero-extended. In hardware mode, that read does not acknowledge.
- R6: In hardware mode, hw_vec_o shows the captured source index, and a cycle with hw_ack_i=1 while irq_o is high acknowledges. In software mode, hw_ack_i is ignored.
- R7: On acknowledge, the current priority is pushed onto the stack and replaced by the captured priority. irq_o is 0 in the cycle after the acknowledge and can be 1 again no earlier than the cycle after that.
- R8: A write at address 2 (end of interrupt) pops the stack into the current priority.
- R9: A write at address 0 sets the current priority from reg_wdata_i. A read at address 0 returns the current priority.
- R10: The stack holds 14 entries. A push when it is full drops the pushed value, although the current priority is still updated. A pop when it is empty leaves the current priority unchanged. Both set lifo_err_o, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | N_SRC | Interrupt request lines, one per source |
| src_pri_i | input | N_SRC*PRI_W | Priority of each source, source i in bits [i*PRI_W +: PRI_W] |
| hw_vec_mode_i | input | 1 | 1 selects hardware-vector acknowledge, 0 selects software-vector acknowledge |
| hw_ack_i | input | 1 | Hardware-vector acknowledge strobe |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 for a write, 0 for a read |
| reg_addr_i | input | 2 | 0 current priority, 1 acknowledge, 2 end of interrupt |
| reg_wdata_i | input | PRI_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| hw_vec_o | output | $clog2(N_SRC) | Vector number of the captured source |
| cur_pri_o | output | PRI_W | Current priority |
| lifo_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench replays the nesting case: the level is raised to 1, a level-2 source is captured, and then a level-3 source arrives. The vector must stay on the level-2 source until it is acknowledged. The bench then checks that irq_o drops for exactly one cycle before the level-3 source appears; a design that re-arbitrates freely would switch vectors early. Equal-priority blocking and index tie-breaks are probed, because a non-strict compare or a reversed scan picks the wrong source. The bench also checks that each acknowledge path is dead in the other mode. Fifteen nested acknowledges then overfill the stack, and the first pop must restore 13, not 14. Any other value shows that the full push was not dropped. A pop on an empty stack must leave the level unchanged.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    REG_CPR  = 2'd0,
    REG_ACK  = 2'd1,
    REG_EOI  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int N_SRC = 8,
  parameter int PRI_W = 4,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*PRI_W-1:0] pri_i,
  input  logic [PRI_W-1:0]       cur_pri_i,
  output logic                   win_valid_o,
  output logic [VEC_W-1:0]       win_idx_o,
  output logic [PRI_W-1:0]       win_pri_o
);
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_pri_o   = cur_pri_i;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && pri_i[i*PRI_W +: PRI_W] > win_pri_o) begin
        win_valid_o = 1'b1;
        win_idx_o   = VEC_W'(i);
        win_pri_o   = pri_i[i*PRI_W +: PRI_W];
      end
    end
  end

  a_r2_win_above_cur: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (req_i[win_idx_o] && pri_i[win_idx_o*PRI_W +: PRI_W] > cur_pri_i));
endmodule

// File: rtl/prio_irq_lifo.sv
module prio_irq_lifo #(
  parameter int PRI_W = 4,
  parameter int DEPTH = 14,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PRI_W-1:0] push_data_i,
  input  logic             pop_i,
  output logic [PRI_W-1:0] top_o,
  output logic             empty_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [PRI_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_m1;
  logic             full;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_m1  = cnt_q - 1'b1;
  assign top_o   = mem_q[cnt_m1[IDX_W-1:0]];
  assign ovf_o   = push_i && full;
  assign unf_o   = pop_i && empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full) begin
      mem_q[cnt_q[IDX_W-1:0]] <= push_data_i;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !push_i && !empty_o) begin
      cnt_q <= cnt_m1;
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r10_full_push_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) |=> $stable(cnt_q));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int PRI_W  = 4,
  parameter int DEPTH  = 14,
  parameter int DATA_W = 8,
  localparam int VEC_W = $clog2(N_SRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       irq_src_i,
  input  logic [N_SRC*PRI_W-1:0] src_pri_i,
  input  logic                   hw_vec_mode_i,
  input  logic                   hw_ack_i,
  input  logic                   reg_req_i,
  input  logic                   reg_we_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [PRI_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic                   irq_o,
  output logic [VEC_W-1:0]       hw_vec_o,
  output logic [PRI_W-1:0]       cur_pri_o,
  output logic                   lifo_err_o
);
  reg_sel_e         sel;
  logic             win_valid;
  logic [VEC_W-1:0] win_idx;
  logic [PRI_W-1:0] win_pri;
  logic             cap_valid_q;
  logic [VEC_W-1:0] cap_idx_q;
  logic [PRI_W-1:0] cap_pri_q;
  logic [PRI_W-1:0] cur_pri_q;
  logic             err_q;
  logic             ack, ack_sw, ack_hw, wr_cpr, wr_eoi;
  logic [PRI_W-1:0] lifo_top;
  logic             lifo_empty, lifo_ovf, lifo_unf;

  assign sel    = reg_sel_e'(reg_addr_i);
  assign ack_sw = reg_req_i && !reg_we_i && sel == REG_ACK && !hw_vec_mode_i && cap_valid_q;
  assign ack_hw = hw_ack_i && hw_vec_mode_i && cap_valid_q;
  assign ack    = ack_sw || ack_hw;
  // an acknowledge takes the cycle; a coincident register write is dropped
  assign wr_cpr = reg_req_i && reg_we_i && sel == REG_CPR && !ack;
  assign wr_eoi = reg_req_i && reg_we_i && sel == REG_EOI && !ack;

  prio_irq_arb #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (irq_src_i),
    .pri_i       (src_pri_i),
    .cur_pri_i   (cur_pri_q),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_pri_o   (win_pri)
  );

  prio_irq_lifo #(.PRI_W(PRI_W), .DEPTH(DEPTH)) u_lifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ack),
    .push_data_i (cur_pri_q),
    .pop_i       (wr_eoi),
    .top_o       (lifo_top),
    .empty_o     (lifo_empty),
    .ovf_o       (lifo_ovf),
    .unf_o       (lifo_unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_valid_q <= 1'b0;
      cap_idx_q   <= '0;
      cap_pri_q   <= '0;
    end else if (ack) begin
      cap_valid_q <= 1'b0;
    end else if (!cap_valid_q && win_valid) begin
      cap_valid_q <= 1'b1;
      cap_idx_q   <= win_idx;
      cap_pri_q   <= win_pri;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_pri_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (ack)                       cur_pri_q <= cap_pri_q;
      else if (wr_cpr)               cur_pri_q <= reg_wdata_i;
      else if (wr_eoi && !lifo_empty) cur_pri_q <= lifo_top;
      if (lifo_ovf || lifo_unf)      err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      REG_CPR: reg_rdata_o = DATA_W'(cur_pri_q);
      REG_ACK: reg_rdata_o = DATA_W'(cap_idx_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o      = cap_valid_q;
  assign hw_vec_o   = cap_idx_q;
  assign cur_pri_o  = cur_pri_q;
  assign lifo_err_o = err_q;

  a_r7_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !irq_o);
  a_r7_pri_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> cur_pri_o == $past(cap_pri_q));
  a_r4_vec_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack) |=> (irq_o && $stable(hw_vec_o)));
  a_r8_pop_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_eoi && !lifo_empty) |=> cur_pri_o == $past(lifo_top));
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lifo_err_o |=> lifo_err_o);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int N_SRC = 8;
  localparam int PRI_W = 4;
  localparam int DATA_W = 8;
  localparam int VEC_W = $clog2(N_SRC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC-1:0] src = '0;
  logic [N_SRC*PRI_W-1:0] pri = '0;
  logic hw_mode = 1'b0, hw_ack = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [PRI_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;
  logic [VEC_W-1:0] vec;
  logic [PRI_W-1:0] cur;
  logic err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .src_pri_i(pri),
    .hw_vec_mode_i(hw_mode), .hw_ack_i(hw_ack), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .hw_vec_o(vec), .cur_pri_o(cur), .lifo_err_o(err)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src = '0; pri = '0; hw_mode = 0; hw_ack = 0; req = 0; we = 0;
    tick(); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic set_src(int i, int p, bit on);
    pri[i*PRI_W +: PRI_W] = PRI_W'(p);
    src[i] = on;
  endtask

  task automatic sw_ack(output int v);
    req = 1; we = 0; addr = 2'd1; #1 v = int'(rdata);
    tick(); req = 0;
  endtask

  task automatic reg_wr(int a, int d);
    req = 1; we = 1; addr = 2'(a); wdata = PRI_W'(d);
    tick(); req = 0; we = 0;
  endtask

  task automatic t_reset();
    do_reset();
    addr = 2'd0; #1;
    check("R1 irq", int'(irq), 0);
    check("R1 cur_pri", int'(cur), 0);
    check("R1 err", int'(err), 0);
    check("R1 cpr read", int'(rdata), 0);
  endtask

  task automatic t_basic();
    int v;
    do_reset();
    set_src(3, 5, 1); tick();
    check("R2 irq raised", int'(irq), 1);
    sw_ack(v);
    check("R5 ack vector", v, 3);
    check("R7 irq low after ack", int'(irq), 0);
    check("R7 cur_pri", int'(cur), 5);
    tick();
    check("R2 equal blocked", int'(irq), 0);
    set_src(3, 0, 0); set_src(4, 4, 1); tick(); tick();
    check("R2 lower blocked", int'(irq), 0);
    set_src(4, 6, 1); tick();
    check("R2 higher passes", int'(irq), 1);
    addr = 2'd1; #1;
    check("R5 vector", int'(rdata), 4);
    addr = 2'd3; #1;
    check("R5 spare addr reads 0", int'(rdata), 0);
  endtask

  task automatic t_latch();
    int v;
    do_reset();
    reg_wr(0, 1);
    check("R9 cpr write", int'(cur), 1);
    addr = 2'd0; #1;
    check("R9 cpr read", int'(rdata), 1);
    set_src(1, 2, 1); tick();
    check("R4 first capture", int'(vec), 1);
    set_src(6, 3, 1); tick(); tick();
    check("R4 held irq", int'(irq), 1);
    check("R4 held vector", int'(vec), 1);
    sw_ack(v);
    check("R4 acked vector", v, 1);
    check("R7 gap cycle", int'(irq), 0);
    check("R7 cur after ack", int'(cur), 2);
    tick();
    check("R7 reassert", int'(irq), 1);
    check("R7 new vector", int'(vec), 6);
    sw_ack(v);
    check("R7 cur nested", int'(cur), 3);
    set_src(1, 0, 0); set_src(6, 0, 0);
    reg_wr(2, 0);
    check("R8 pop 1", int'(cur), 2);
    reg_wr(2, 0);
    check("R8 pop 2", int'(cur), 1);
    check("R10 no err yet", int'(err), 0);
    reg_wr(2, 0);
    check("R10 underflow cur kept", int'(cur), 1);
    check("R10 underflow err", int'(err), 1);
    tick();
    check("R10 err sticky", int'(err), 1);
  endtask

  task automatic t_tie_hw();
    do_reset();
    hw_mode = 1;
    set_src(0, 3, 1); set_src(5, 7, 1); set_src(2, 7, 1); tick();
    check("R3 tie lowest index", int'(vec), 2);
    req = 1; we = 0; addr = 2'd1; tick(); req = 0;
    check("R5 read no ack in hw mode irq", int'(irq), 1);
    check("R5 read no ack in hw mode cur", int'(cur), 0);
    hw_ack = 1; tick(); hw_ack = 0;
    check("R6 hw ack irq", int'(irq), 0);
    check("R6 hw ack cur", int'(cur), 7);
    set_src(2, 0, 0); set_src(7, 9, 1); tick(); tick();
    check("R3 highest wins", int'(vec), 7);
    hw_mode = 0;
    hw_ack = 1; tick(); hw_ack = 0;
    check("R6 hw ack ignored sw mode irq", int'(irq), 1);
    check("R6 hw ack ignored sw mode cur", int'(cur), 7);
  endtask

  task automatic t_overflow();
    int v;
    do_reset();
    for (int k = 1; k <= 15; k++) begin
      set_src(0, k, 1); tick();
      if (!irq) check("R10 nest irq", int'(irq), 1);
      sw_ack(v);
      if (k == 14) check("R10 full no err", int'(err), 0);
    end
    check("R10 cur top", int'(cur), 15);
    check("R10 overflow err", int'(err), 1);
    set_src(0, 0, 0);
    reg_wr(2, 0);
    check("R10 dropped push", int'(cur), 13);
    check("R10 err stays", int'(err), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_latch();
    t_tie_hw();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule